// File: doc/BRIEF.md
# Domain-Tagged DMA Translation Cache with Speculative Side Buffer

This block caches translations from a device's virtual I/O page frame to a host page frame, keyed by a 16-bit domain number together with the page frame. Its main store is two-way set associative. The set is chosen only from the low bits of the virtual frame, so two domains that use the same frame land in the same set. A small fully associative side buffer sits next to the main store and holds translations that were fetched ahead of use. A lookup searches both structures at once and answers in the same cycle.

A lookup that finds nothing raises a walk request. The requester keeps the lookup stable until the page-walk result comes back on the fill port, and the lookup hits in the cycle after the fill. A translation that hits only in the side buffer is moved into the main store. It leaves the side buffer at the same clock edge, and the move uses the normal victim choice of its set. Translations flagged as short-lived can be evicted ahead of the replacement order when hinting is switched on. An invalidate port removes one domain/page pair from both structures.

Top module: `iotlb_pf`

## Requirements
- R1: A lookup that matches a valid main-store entry drives `lk_hit` high and `lk_hpn` to that entry's host frame in the same cycle, with `walk_req` low.
- R2: A lookup that matches nothing drives `lk_hit` low and `walk_req` high. After a fill with the same domain and frame, the held lookup hits in the next cycle with the filled host frame.
- R3: A hit needs both the domain and the frame to match. A frame cached for one domain misses for another, and both domains' entries for the same frame can be resident together.
- R4: The set index is the low log2(SETS) bits of the virtual frame (bits 3:0 by default), and each set holds two entries. Filling a third distinct key into a full set evicts one of the two resident entries and leaves other sets untouched.
- R5: With hinting off, the evicted entry is the one least recently used. Both a lookup hit and a write count as a use.
- R6: With `eh_en` high, if exactly one of the two resident entries carries the short-lived flag, that entry is evicted even if it was used most recently. With `eh_en` low the flag has no effect.
- R7: An entry written through the prefetch port can be found by a lookup from the next cycle on, and it evicts nothing from the main store when it is written.
- R8: A lookup that hits only in the side buffer returns its host frame. At that edge the entry moves into the main store, using the normal victim choice, and its side-buffer slot becomes free.
- R9: The side buffer holds PF_DEPTH entries (4 by default). Inserting into a full side buffer drops the entry that has been there longest.
- R10: The short-lived flag does not change which side-buffer entry is dropped, whatever the value of `eh_en`.
- R11: An invalidate removes every entry matching its domain and frame from both structures, from the next cycle on. Entries of other domains are kept.
- R12: After reset, every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eh_en | input | 1 | Enables eviction of short-lived entries first |
| lk_valid | input | 1 | Lookup request |
| lk_dom | input | 16 | Lookup domain |
| lk_vpn | input | 20 | Lookup virtual page frame |
| lk_hit | output | 1 | Lookup found a translation |
| lk_hpn | output | 24 | Host page frame of the hit |
| walk_req | output | 1 | Lookup missed; page walk needed |
| fill_valid | input | 1 | Page-walk result write |
| fill_dom | input | 16 | Fill domain |
| fill_vpn | input | 20 | Fill virtual page frame |
| fill_hpn | input | 24 | Fill host page frame |
| fill_tm | input | 1 | Fill is a short-lived mapping |
| pf_valid | input | 1 | Prefetched translation write |
| pf_dom | input | 16 | Prefetch domain |
| pf_vpn | input | 20 | Prefetch virtual page frame |
| pf_hpn | input | 24 | Prefetch host page frame |
| pf_tm | input | 1 | Prefetch is a short-lived mapping |
| inv_valid | input | 1 | Invalidate request |
| inv_dom | input | 16 | Invalidate domain |
| inv_vpn | input | 20 | Invalidate virtual page frame |

## Verification
Lookup results (`lk_hit`, `lk_hpn`, `walk_req`) depend only on the lookup inputs and the stored state, so they are due in the cycle the lookup is presented. Fills, prefetch writes, invalidates and the promotion of a side-buffer hit all take effect at the next rising edge, so their outcome shows up only in a lookup one cycle later. The bench drives all inputs on the falling edge and reads outputs a few nanoseconds after that. A queue-based model, updated on the rising edge from the same inputs, predicts every lookup, and directed sequences add explicit expectations for eviction order, promotion and invalidation.

// File: rtl/iotlb_pkg.sv
`timescale 1ns/1ps
package iotlb_pkg;
    localparam int DOM_W = 16;
    localparam int VPN_W = 20;
    localparam int HPN_W = 24;

    typedef logic [DOM_W-1:0] dom_t;
    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [HPN_W-1:0] hpn_t;
endpackage

// File: rtl/iotlb_main.sv
`timescale 1ns/1ps
// Two-way set-associative store with LRU and short-lived-entry victim preference.
module iotlb_main
    import iotlb_pkg::*;
#(
    parameter int SETS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eh_en,
    input  logic lk_vld,
    input  dom_t lk_dom,
    input  vpn_t lk_vpn,
    output logic lk_hit,
    output hpn_t lk_hpn,
    input  logic wr_vld,
    input  dom_t wr_dom,
    input  vpn_t wr_vpn,
    input  hpn_t wr_hpn,
    input  logic wr_tm,
    input  logic inv_vld,
    input  dom_t inv_dom,
    input  vpn_t inv_vpn
);
    localparam int WAYS  = 2;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic vld;
        logic tm;
        dom_t dom;
        tag_t tag;
        hpn_t hpn;
    } way_t;

    typedef struct packed {
        way_t [SETS-1:0][WAYS-1:0] ent;
        logic [SETS-1:0]           lru;   // way to evict next
    } st_t;

    st_t q, d;

    function automatic logic [WAYS-1:0] probe(st_t s, idx_t i, dom_t dm, tag_t t);
        logic [WAYS-1:0] m;
        for (int w = 0; w < WAYS; w++)
            m[w] = s.ent[i][w].vld && (s.ent[i][w].dom == dm) && (s.ent[i][w].tag == t);
        return m;
    endfunction

    idx_t            lk_i, inv_i, wr_i;
    logic [WAYS-1:0] lk_m, inv_m, wr_m;
    logic            wr_way;

    always_comb begin
        lk_i  = lk_vpn[IDX_W-1:0];
        inv_i = inv_vpn[IDX_W-1:0];
        wr_i  = wr_vpn[IDX_W-1:0];
        lk_m  = lk_vld  ? probe(q, lk_i, lk_dom, lk_vpn[VPN_W-1:IDX_W]) : '0;
        inv_m = inv_vld ? probe(q, inv_i, inv_dom, inv_vpn[VPN_W-1:IDX_W]) : '0;
        wr_m  = probe(q, wr_i, wr_dom, wr_vpn[VPN_W-1:IDX_W]);

        lk_hit = |lk_m;
        lk_hpn = lk_m[1] ? q.ent[lk_i][1].hpn : (lk_m[0] ? q.ent[lk_i][0].hpn : '0);

        // victim: existing copy, then empty way, then hinted entry, then LRU
        if (|wr_m)
            wr_way = wr_m[1];
        else if (!q.ent[wr_i][0].vld)
            wr_way = 1'b0;
        else if (!q.ent[wr_i][1].vld)
            wr_way = 1'b1;
        else if (eh_en && (q.ent[wr_i][0].tm != q.ent[wr_i][1].tm))
            wr_way = q.ent[wr_i][1].tm;
        else
            wr_way = q.lru[wr_i];

        d = q;
        if (lk_hit)
            d.lru[lk_i] = !lk_m[1];
        for (int w = 0; w < WAYS; w++)
            if (inv_m[w])
                d.ent[inv_i][w].vld = 1'b0;
        if (wr_vld) begin
            d.ent[wr_i][wr_way] = '{vld: 1'b1, tm: wr_tm, dom: wr_dom,
                                    tag: wr_vpn[VPN_W-1:IDX_W], hpn: wr_hpn};
            d.lru[wr_i] = !wr_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/iotlb_pfbuf.sv
`timescale 1ns/1ps
// Fully associative side buffer, oldest-first replacement by age rank.
module iotlb_pfbuf
    import iotlb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lk_vld,
    input  dom_t lk_dom,
    input  vpn_t lk_vpn,
    output logic hit,
    output hpn_t hpn,
    output logic tm,
    input  logic take,
    input  logic ins_vld,
    input  dom_t ins_dom,
    input  vpn_t ins_vpn,
    input  hpn_t ins_hpn,
    input  logic ins_tm,
    input  logic inv_vld,
    input  dom_t inv_dom,
    input  vpn_t inv_vpn
);
    localparam int AGE_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             vld;
        logic             tm;
        logic [AGE_W-1:0] age;   // 0 = newest; valid ranks are contiguous
        dom_t             dom;
        vpn_t             vpn;
        hpn_t             hpn;
    } slot_t;

    slot_t [DEPTH-1:0] q, d;
    logic  [DEPTH-1:0] lk_m, inv_m, rm;
    logic  [AGE_W-1:0] dec;
    logic  [CNT_W-1:0] cnt;
    logic  [AGE_W-1:0] slot;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign lk_m[g]  = lk_vld  && q[g].vld && (q[g].dom == lk_dom)  && (q[g].vpn == lk_vpn);
        assign inv_m[g] = inv_vld && q[g].vld && (q[g].dom == inv_dom) && (q[g].vpn == inv_vpn);
    end

    always_comb begin
        hit = |lk_m;
        hpn = '0;
        tm  = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (lk_m[i]) begin
                hpn = q[i].hpn;
                tm  = q[i].tm;
            end

        rm = (take ? lk_m : '0) | inv_m;
        d  = q;
        for (int i = 0; i < DEPTH; i++) begin
            dec = '0;
            for (int j = 0; j < DEPTH; j++)
                if (rm[j] && (q[j].age < q[i].age))
                    dec = dec + 1'b1;
            d[i].age = q[i].age - dec;
            if (rm[i])
                d[i].vld = 1'b0;
        end

        cnt = '0;
        for (int i = 0; i < DEPTH; i++)
            cnt = cnt + CNT_W'(d[i].vld);

        slot = '0;
        if (cnt == CNT_W'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++)
                if (d[i].age == AGE_W'(DEPTH - 1))
                    slot = AGE_W'(i);
        end else begin
            for (int i = DEPTH - 1; i >= 0; i--)
                if (!d[i].vld)
                    slot = AGE_W'(i);
        end

        if (ins_vld) begin
            for (int i = 0; i < DEPTH; i++)
                if (d[i].vld && (AGE_W'(i) != slot))
                    d[i].age = d[i].age + 1'b1;
            d[slot] = '{vld: 1'b1, tm: ins_tm, age: '0, dom: ins_dom,
                        vpn: ins_vpn, hpn: ins_hpn};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/iotlb_pf.sv
`timescale 1ns/1ps
module iotlb_pf
    import iotlb_pkg::*;
#(
    parameter int SETS     = 16,
    parameter int PF_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eh_en,
    input  logic             lk_valid,
    input  logic [DOM_W-1:0] lk_dom,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [HPN_W-1:0] lk_hpn,
    output logic             walk_req,
    input  logic             fill_valid,
    input  logic [DOM_W-1:0] fill_dom,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [HPN_W-1:0] fill_hpn,
    input  logic             fill_tm,
    input  logic             pf_valid,
    input  logic [DOM_W-1:0] pf_dom,
    input  logic [VPN_W-1:0] pf_vpn,
    input  logic [HPN_W-1:0] pf_hpn,
    input  logic             pf_tm,
    input  logic             inv_valid,
    input  logic [DOM_W-1:0] inv_dom,
    input  logic [VPN_W-1:0] inv_vpn
);
    logic main_hit, side_hit, side_tm, take;
    hpn_t main_hpn, side_hpn;
    logic wr_vld, wr_tm;
    dom_t wr_dom;
    vpn_t wr_vpn;
    hpn_t wr_hpn;

    // a side-buffer hit moves to the main store unless a fill owns the write port
    assign take   = lk_valid && !main_hit && side_hit && !fill_valid;
    assign wr_vld = fill_valid || take;
    assign wr_dom = fill_valid ? fill_dom : lk_dom;
    assign wr_vpn = fill_valid ? fill_vpn : lk_vpn;
    assign wr_hpn = fill_valid ? fill_hpn : side_hpn;
    assign wr_tm  = fill_valid ? fill_tm  : side_tm;

    assign lk_hit   = main_hit || side_hit;
    assign lk_hpn   = main_hit ? main_hpn : side_hpn;
    assign walk_req = lk_valid && !lk_hit;

    iotlb_main #(.SETS(SETS)) u_main (
        .clk     (clk),
        .rst_n   (rst_n),
        .eh_en   (eh_en),
        .lk_vld  (lk_valid),
        .lk_dom  (lk_dom),
        .lk_vpn  (lk_vpn),
        .lk_hit  (main_hit),
        .lk_hpn  (main_hpn),
        .wr_vld  (wr_vld),
        .wr_dom  (wr_dom),
        .wr_vpn  (wr_vpn),
        .wr_hpn  (wr_hpn),
        .wr_tm   (wr_tm),
        .inv_vld (inv_valid),
        .inv_dom (inv_dom),
        .inv_vpn (inv_vpn)
    );

    iotlb_pfbuf #(.DEPTH(PF_DEPTH)) u_side (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_vld  (lk_valid),
        .lk_dom  (lk_dom),
        .lk_vpn  (lk_vpn),
        .hit     (side_hit),
        .hpn     (side_hpn),
        .tm      (side_tm),
        .take    (take),
        .ins_vld (pf_valid),
        .ins_dom (pf_dom),
        .ins_vpn (pf_vpn),
        .ins_hpn (pf_hpn),
        .ins_tm  (pf_tm),
        .inv_vld (inv_valid),
        .inv_dom (inv_dom),
        .inv_vpn (inv_vpn)
    );
endmodule

// File: rtl/iotlb_pf_chk.sv
`timescale 1ns/1ps
module iotlb_pf_chk
    import iotlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [DOM_W-1:0] lk_dom,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_hit,
    input logic [HPN_W-1:0] lk_hpn,
    input logic             walk_req,
    input logic             fill_valid,
    input logic [DOM_W-1:0] fill_dom,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [HPN_W-1:0] fill_hpn,
    input logic             pf_valid,
    input logic [DOM_W-1:0] pf_dom,
    input logic [VPN_W-1:0] pf_vpn,
    input logic             inv_valid,
    input logic [DOM_W-1:0] inv_dom,
    input logic [VPN_W-1:0] inv_vpn
);
    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && walk_req && fill_valid && !inv_valid &&
         fill_dom == lk_dom && fill_vpn == lk_vpn)
        |=> (!(lk_valid && lk_dom == $past(lk_dom) && lk_vpn == $past(lk_vpn)) ||
             (lk_hit && lk_hpn == $past(fill_hpn))));   // R2

    AST_PREFETCH_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !inv_valid && !lk_valid)
        |=> (!(lk_valid && lk_dom == $past(pf_dom) && lk_vpn == $past(pf_vpn)) || lk_hit));   // R7

    AST_PROMOTE_KEEPS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_hit && !fill_valid && !inv_valid)
        |=> (!(lk_valid && $stable(lk_dom) && $stable(lk_vpn)) ||
             (lk_hit && $stable(lk_hpn))));   // R8

    AST_INVALIDATE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !fill_valid && !pf_valid && !lk_valid)
        |=> (!(lk_valid && lk_dom == $past(inv_dom) && lk_vpn == $past(inv_vpn)) || !lk_hit));   // R11
endmodule

bind iotlb_pf iotlb_pf_chk u_chk (.*);

// File: tb/iotlb_pf_test.sv
`timescale 1ns/1ps
module iotlb_pf_test;
    logic        clk = 1'b0;
    logic        rst_n, eh_en;
    logic        lk_valid, lk_hit, walk_req;
    logic [15:0] lk_dom;
    logic [19:0] lk_vpn;
    logic [23:0] lk_hpn;
    logic        fill_valid, fill_tm, pf_valid, pf_tm, inv_valid;
    logic [15:0] fill_dom, pf_dom, inv_dom;
    logic [19:0] fill_vpn, pf_vpn, inv_vpn;
    logic [23:0] fill_hpn, pf_hpn;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    iotlb_pf uut (.*);

    // ---------------- behavioural reference ----------------
    typedef struct {
        logic [15:0] d;
        logic [19:0] v;
        logic [23:0] h;
        bit          tm;
    } ment_t;

    ment_t mset[16][$];   // per set, most recent first
    ment_t mpf[$];        // oldest first

    function automatic logic [23:0] hp(logic [15:0] d, logic [19:0] v);
        return {d[3:0], v};
    endfunction

    function automatic void m_look(logic [15:0] d, logic [19:0] v, output bit hit, output logic [23:0] h);
        int s;
        s = int'(v[3:0]);
        hit = 0;
        h = '0;
        for (int k = 0; k < mset[s].size(); k++)
            if (!hit && mset[s][k].d == d && mset[s][k].v == v) begin hit = 1; h = mset[s][k].h; end
        for (int k = 0; k < mpf.size(); k++)
            if (!hit && mpf[k].d == d && mpf[k].v == v) begin hit = 1; h = mpf[k].h; end
    endfunction

    function automatic void m_ins(ment_t e, bit eh);
        int s;
        int vk;
        s = int'(e.v[3:0]);
        for (int k = mset[s].size() - 1; k >= 0; k--)
            if (mset[s][k].d == e.d && mset[s][k].v == e.v) mset[s].delete(k);
        if (mset[s].size() == 2) begin
            vk = 1;
            if (eh && (mset[s][0].tm != mset[s][1].tm)) vk = mset[s][1].tm ? 1 : 0;
            mset[s].delete(vk);
        end
        mset[s].push_front(e);
    endfunction

    always @(posedge clk) begin : m_step
        ment_t pr;
        bit    dopr;
        bit    found;
        int    s;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mset[i].delete();
            mpf.delete();
        end else begin
            dopr = 0;
            found = 0;
            if (lk_valid) begin
                s = int'(lk_vpn[3:0]);
                for (int k = 0; k < mset[s].size(); k++)
                    if (!found && mset[s][k].d == lk_dom && mset[s][k].v == lk_vpn) begin
                        pr = mset[s][k];
                        mset[s].delete(k);
                        mset[s].push_front(pr);
                        found = 1;
                    end
                for (int k = 0; k < mpf.size(); k++)
                    if (!found && mpf[k].d == lk_dom && mpf[k].v == lk_vpn) begin
                        found = 1;
                        if (!fill_valid) begin
                            dopr = 1;
                            pr = mpf[k];
                            mpf.delete(k);
                        end
                    end
            end
            if (inv_valid) begin
                s = int'(inv_vpn[3:0]);
                for (int k = mset[s].size() - 1; k >= 0; k--)
                    if (mset[s][k].d == inv_dom && mset[s][k].v == inv_vpn) mset[s].delete(k);
                for (int k = mpf.size() - 1; k >= 0; k--)
                    if (mpf[k].d == inv_dom && mpf[k].v == inv_vpn) mpf.delete(k);
            end
            if (fill_valid) m_ins('{fill_dom, fill_vpn, fill_hpn, fill_tm}, eh_en);
            else if (dopr)  m_ins(pr, eh_en);
            if (pf_valid) begin
                if (mpf.size() == 4) void'(mpf.pop_front());
                mpf.push_back('{pf_dom, pf_vpn, pf_hpn, pf_tm});
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // model comparison on every cycle with a lookup
    always begin
        bit          mh;
        logic [23:0] mhp;
        @(negedge clk);
        #3;
        if (rst_n && lk_valid) begin
            m_look(lk_dom, lk_vpn, mh, mhp);
            chk("R1 R2 model", "hit", 32'(lk_hit), 32'(mh));
            chk("R1 R2 model", "walk_req", 32'(walk_req), 32'(!mh));
            if (mh) chk("R1 model", "hpn", 32'(lk_hpn), 32'(mhp));
        end
    end

    task automatic clr();
        lk_valid = 0; fill_valid = 0; pf_valid = 0; inv_valid = 0;
    endtask

    task automatic look(logic [15:0] d, logic [19:0] v, bit eh, logic [23:0] eh_hpn, string req);
        @(negedge clk);
        clr();
        lk_valid = 1; lk_dom = d; lk_vpn = v;
        #2;
        chk(req, "lk_hit", 32'(lk_hit), 32'(eh));
        chk(req, "walk_req", 32'(walk_req), 32'(!eh));
        if (eh) chk(req, "lk_hpn", 32'(lk_hpn), 32'(eh_hpn));
    endtask

    task automatic fl(logic [15:0] d, logic [19:0] v, bit tm);
        @(negedge clk);
        clr();
        fill_valid = 1; fill_dom = d; fill_vpn = v; fill_hpn = hp(d, v); fill_tm = tm;
    endtask

    task automatic pfi(logic [15:0] d, logic [19:0] v, bit tm);
        @(negedge clk);
        clr();
        pf_valid = 1; pf_dom = d; pf_vpn = v; pf_hpn = hp(d, v); pf_tm = tm;
    endtask

    task automatic inv(logic [15:0] d, logic [19:0] v);
        @(negedge clk);
        clr();
        inv_valid = 1; inv_dom = d; inv_vpn = v;
    endtask

    // miss, fill while the lookup is held, then hit
    task automatic walk(logic [15:0] d, logic [19:0] v, bit tm, string req);
        look(d, v, 0, '0, req);
        @(negedge clk);
        clr();
        lk_valid = 1; lk_dom = d; lk_vpn = v;
        fill_valid = 1; fill_dom = d; fill_vpn = v; fill_hpn = hp(d, v); fill_tm = tm;
        #2;
        chk(req, "walk_req during fill", 32'(walk_req), 32'd1);
        look(d, v, 1, hp(d, v), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; eh_en = 0;
        lk_dom = '0; lk_vpn = '0; fill_dom = '0; fill_vpn = '0; fill_hpn = '0; fill_tm = 0;
        pf_dom = '0; pf_vpn = '0; pf_hpn = '0; pf_tm = 0; inv_dom = '0; inv_vpn = '0;
        clr();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        look(16'd1, 20'h00012, 0, '0, "R12 reset empty");
        walk(16'd1, 20'h00012, 0, "R2 walk and fill");
        look(16'd1, 20'h00012, 1, hp(1, 20'h00012), "R1 main hit");

        // domain is part of the tag, not the index
        look(16'd2, 20'h00012, 0, '0, "R3 other domain misses");
        walk(16'd2, 20'h00012, 0, "R3 second domain fill");
        look(16'd2, 20'h00012, 1, hp(2, 20'h00012), "R3 both resident dom2");
        look(16'd1, 20'h00012, 1, hp(1, 20'h00012), "R3 both resident dom1");

        // third key in set 2 evicts the LRU entry (dom2)
        fl(16'd1, 20'h00022, 0);
        look(16'd2, 20'h00012, 0, '0, "R4 third key evicts");
        look(16'd1, 20'h00012, 1, hp(1, 20'h00012), "R4 survivor");
        look(16'd1, 20'h00022, 1, hp(1, 20'h00022), "R4 new entry");
        look(16'd1, 20'h00012, 1, hp(1, 20'h00012), "R5 refresh");
        fl(16'd1, 20'h00032, 0);
        look(16'd1, 20'h00022, 0, '0, "R5 LRU evicted");
        look(16'd1, 20'h00012, 1, hp(1, 20'h00012), "R5 recent kept");
        fl(16'd1, 20'h00013, 0);
        look(16'd1, 20'h00032, 1, hp(1, 20'h00032), "R4 other set untouched");
        look(16'd1, 20'h00013, 1, hp(1, 20'h00013), "R4 set 3 entry");

        // eviction hints on: short-lived entry goes first even when recent
        eh_en = 1;
        fl(16'd1, 20'h00005, 1);
        fl(16'd1, 20'h00015, 0);
        look(16'd1, 20'h00005, 1, hp(1, 20'h00005), "R6 short-lived made recent");
        fl(16'd1, 20'h00025, 0);
        look(16'd1, 20'h00005, 0, '0, "R6 hinted victim evicted");
        look(16'd1, 20'h00015, 1, hp(1, 20'h00015), "R6 LRU entry kept");
        eh_en = 0;
        fl(16'd1, 20'h00006, 1);
        fl(16'd1, 20'h00016, 0);
        look(16'd1, 20'h00006, 1, hp(1, 20'h00006), "R6 hints off refresh");
        fl(16'd1, 20'h00026, 0);
        look(16'd1, 20'h00016, 0, '0, "R6 hints off LRU evicted");
        look(16'd1, 20'h00006, 1, hp(1, 20'h00006), "R6 hints off flag ignored");

        // prefetch buffer and promotion
        fl(16'd1, 20'h00007, 0);
        fl(16'd1, 20'h00017, 0);
        pfi(16'd1, 20'h00027, 0);
        pfi(16'd1, 20'h00008, 0);
        pfi(16'd1, 20'h00009, 0);
        pfi(16'd1, 20'h0000A, 0);
        look(16'd1, 20'h00007, 1, hp(1, 20'h00007), "R7 main undisturbed");
        look(16'd1, 20'h00017, 1, hp(1, 20'h00017), "R7 main undisturbed");
        look(16'd1, 20'h00027, 1, hp(1, 20'h00027), "R7 prefetched hit");
        look(16'd1, 20'h00027, 1, hp(1, 20'h00027), "R8 promoted hit");
        look(16'd1, 20'h00007, 0, '0, "R8 promotion used LRU victim");
        pfi(16'd1, 20'h0000B, 0);
        look(16'd1, 20'h00008, 1, hp(1, 20'h00008), "R8 slot freed oldest kept");
        look(16'd1, 20'h00009, 1, hp(1, 20'h00009), "R8 side entry");
        look(16'd1, 20'h0000A, 1, hp(1, 20'h0000A), "R8 side entry");
        look(16'd1, 20'h0000B, 1, hp(1, 20'h0000B), "R8 side entry");

        // FIFO replacement, flag ignored in the side buffer
        eh_en = 1;
        pfi(16'd1, 20'h0000C, 0);
        pfi(16'd1, 20'h0000D, 1);
        pfi(16'd1, 20'h0000E, 1);
        pfi(16'd1, 20'h0000F, 1);
        pfi(16'd1, 20'h0001F, 1);
        look(16'd1, 20'h0000C, 0, '0, "R9 R10 oldest dropped");
        look(16'd1, 20'h0000D, 1, hp(1, 20'h0000D), "R10 short-lived kept");
        look(16'd1, 20'h0001F, 1, hp(1, 20'h0001F), "R9 newest present");
        eh_en = 0;

        // invalidation
        inv(16'd1, 20'h00012);
        look(16'd1, 20'h00012, 0, '0, "R11 main entry removed");
        pfi(16'd3, 20'h00030, 0);
        inv(16'd3, 20'h00030);
        look(16'd3, 20'h00030, 0, '0, "R11 side entry removed");
        inv(16'd2, 20'h00032);
        look(16'd1, 20'h00032, 1, hp(1, 20'h00032), "R11 other domain kept");

        @(negedge clk);
        clr();
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule